// File: doc/BRIEF.md
# Floppy Controller Command Sequencer

This block is the host-facing phase engine of a PC-style floppy disk controller. The host sees two byte-wide things: a main status byte, which is always readable, and a data port with separate write and read strobes. The sequencer collects the command bytes of the opcodes it recognises and then runs an execution phase. For READ and VERIFY the execution phase is modelled in the simplest way. READ ID waits for a programmable number of cycles. A READ without DMA streams sector data to the host through the data port. After execution the block offers the result bytes one at a time and drives the interrupt line to the handshake rules of the legacy controller.

Sector contents come from a byte source outside the block. `media_data_i` presents the current byte, and `media_adv_o` pulses once for every byte the host takes. The present cylinder of the drive arrives on `cur_cyl_i`. The design has five enumerated states, with these transitions:

- ST_CMD goes to ST_PARAM on an accepted opcode, or to ST_RESULT on an unknown one.
- ST_PARAM goes, on its last byte, to ST_DELAY (READ ID), to ST_XFER (non-DMA READ with data) or to ST_RESULT (every other case).
- ST_DELAY goes to ST_RESULT when its counter is exhausted.
- ST_XFER goes to ST_RESULT when the last data byte is read.
- ST_RESULT goes back to ST_CMD when the last result byte is read.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After reset the status byte is 0x80 and the interrupt is low.
- R2: The status bits are ready 0x80, direction-to-host 0x40, non-DMA execution 0x20 and busy 0x10. Each phase shows a fixed value: ST_CMD 0x80, ST_PARAM 0x90, ST_DELAY 0x10, ST_XFER 0xF0 and ST_RESULT 0xD0.
- R3: The opcode class comes from bits [4:0], and bit 7 is the multi-track flag. READ (0x06) and VERIFY (0x16) take 9 bytes: opcode, drive select (head in bit 2, drive in bits 1:0), cylinder, head, first sector, size code, last sector, gap, data length. READ ID (0x0A) takes 2 bytes: opcode and drive select. Each of these three returns 7 result bytes.
- R4: Any other opcode gives exactly one result byte, 0x80, with no interrupt, and the block then returns to ST_CMD.
- R5: A READ with dma_en_i low streams (last-first+1)×SECTOR_BYTES bytes. The count is doubled when the multi-track flag is set and the head in the drive select byte is 0. Bytes appear in source order, with one media_adv_o pulse for each byte read.
- R6: VERIFY, and a READ with dma_en_i high, move no data and go straight to ST_RESULT with the interrupt raised.
- R7: The interrupt rises when execution ends and stays high through the result bytes. It falls on the read of the last result byte, and the status byte then shows 0x80.
- R8: The interrupt is low during command collection and during the READ ID wait.
- R9: READ/VERIFY results are ST0, ST1=0, ST2=0, the cylinder byte, the final head, the last-sector byte and the size code. ST0 is final_head<<2 | drive. The final head is 1 after a multi-track run that started on head 0; otherwise it is the drive select head.
- R10: A last-sector value above SPT skips the data phase. ST0 is then 0x20 | head<<2 | drive, and the final head is the drive select head.
- R11: READ ID holds ST_DELAY for ID_DELAY+1 cycles. It then returns ST0=head<<2|drive, 0, 0, cur_cyl_i, head, 1, 2.
- R12: A data-port write is ignored outside ST_CMD/ST_PARAM, and a read is ignored outside ST_XFER/ST_RESULT. When both strobes arrive in the same cycle, only the permitted one takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en_i | input | 1 | DMA mode selected (READ moves no bytes through the port) |
| fifo_wr_i | input | 1 | Host write strobe to the data port |
| fifo_wdata_i | input | 8 | Host write byte |
| fifo_rd_i | input | 1 | Host read strobe from the data port |
| fifo_rdata_o | output | 8 | Byte offered to the host (data or result) |
| status_o | output | 8 | Main status byte |
| irq_o | output | 1 | Interrupt request |
| media_data_i | input | 8 | Current sector byte from the media source |
| media_adv_o | output | 1 | Media source advance, one pulse per byte taken |
| cur_cyl_i | input | 8 | Present cylinder of the drive |

## Verification
A host write strobe and a host read strobe can arrive in the same cycle, and the block must honour only the one that the current phase allows. The bench raises both strobes together in two places. In ST_CMD, with a READ ID opcode, the phase must become 0x90. In ST_RESULT, the byte returned must be the first expected result while the status stays 0xD0. The remaining result sequence is then compared against the scoreboard, so a write that wrongly took effect, or a read that was lost, shows up as a shifted or missing byte.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

    localparam int CMD_MAX_BYTES = 9;
    localparam int RES_BYTES     = 7;

    localparam logic [7:0] MSR_RQM    = 8'h80;
    localparam logic [7:0] MSR_DIO    = 8'h40;
    localparam logic [7:0] MSR_NONDMA = 8'h20;
    localparam logic [7:0] MSR_BUSY   = 8'h10;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_PARAM,
        ST_DELAY,
        ST_XFER,
        ST_RESULT
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_RW_READ,
        OP_RW_VERIFY,
        OP_READID,
        OP_INVALID
    } op_kind_t;

    function automatic op_kind_t decode_op(input logic [7:0] b);
        op_kind_t k;
        unique case (b[4:0])
            5'h06:   k = OP_RW_READ;
            5'h16:   k = OP_RW_VERIFY;
            5'h0A:   k = OP_READID;
            default: k = OP_INVALID;
        endcase
        return k;
    endfunction

    function automatic logic [3:0] cmd_len(input op_kind_t k);
        logic [3:0] n;
        unique case (k)
            OP_RW_READ, OP_RW_VERIFY: n = 4'd9;
            OP_READID:                n = 4'd2;
            default:                  n = 4'd1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/fdc_cmd_capture.sv
module fdc_cmd_capture #(
    parameter int NBYTES = 9,
    localparam int IDX_W = $clog2(NBYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   first_i,
    input  logic                   next_i,
    input  logic [7:0]             data_i,
    output logic [NBYTES-1:0][7:0] bytes_o,
    output logic [IDX_W-1:0]       idx_o
);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (first_i) begin
            idx_q <= IDX_W'(1);
        end else if (next_i) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bytes_o[g] <= '0;
            end else if (first_i && (g == 0)) begin
                bytes_o[g] <= data_i;
            end else if (next_i && (idx_q == IDX_W'(g))) begin
                bytes_o[g] <= data_i;
            end
        end
    end

    assign idx_o = idx_q;

endmodule

// File: rtl/fdc_down_counter.sv
module fdc_down_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (load_i) begin
            cnt_o <= val_i;
        end else if (dec_i) begin
            cnt_o <= cnt_o - W'(1);
        end
    end

endmodule

// File: rtl/fdc_result_mux.sv
module fdc_result_mux
    import fdc_seq_pkg::*;
(
    input  op_kind_t                      op_i,
    input  logic [CMD_MAX_BYTES-1:0][7:0] bytes_i,
    input  logic                          bad_i,
    input  logic [7:0]                    cyl_i,
    input  logic [2:0]                    idx_i,
    output logic [7:0]                    data_o,
    output logic                          last_o
);

    logic [1:0] drv;
    logic       hd;
    logic       mt;
    logic       fin_hd;
    logic [7:0] st0;
    logic       unused_bits;

    assign drv    = bytes_i[1][1:0];
    assign hd     = bytes_i[1][2];
    assign mt     = bytes_i[0][7];
    assign fin_hd = (op_i != OP_READID && !bad_i && mt && !hd) ? 1'b1 : hd;
    assign st0    = {2'b00, bad_i, 2'b00, fin_hd, drv};

    assign unused_bits = ^{bytes_i[0][6:0], bytes_i[1][7:3], bytes_i[3], bytes_i[4],
                           bytes_i[7], bytes_i[8]};

    always_comb begin
        data_o = 8'h00;
        if (op_i == OP_INVALID) begin
            data_o = 8'h80;
        end else if (op_i == OP_READID) begin
            unique case (idx_i)
                3'd0:    data_o = st0;
                3'd3:    data_o = cyl_i;
                3'd4:    data_o = {7'b0, hd};
                3'd5:    data_o = 8'h01;
                3'd6:    data_o = 8'h02;
                default: data_o = 8'h00;
            endcase
        end else begin
            unique case (idx_i)
                3'd0:    data_o = st0;
                3'd3:    data_o = bytes_i[2];
                3'd4:    data_o = {7'b0, fin_hd};
                3'd5:    data_o = bytes_i[6];
                3'd6:    data_o = bytes_i[5];
                default: data_o = 8'h00;
            endcase
        end
    end

    assign last_o = (op_i == OP_INVALID) ? (idx_i == 3'd0) : (idx_i == 3'(RES_BYTES - 1));

endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
    import fdc_seq_pkg::*;
#(
    parameter int SPT          = 18,
    parameter int SECTOR_BYTES = 512,
    parameter int ID_DELAY     = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dma_en_i,
    input  logic       fifo_wr_i,
    input  logic [7:0] fifo_wdata_i,
    input  logic       fifo_rd_i,
    output logic [7:0] fifo_rdata_o,
    output logic [7:0] status_o,
    output logic       irq_o,
    input  logic [7:0] media_data_i,
    output logic       media_adv_o,
    input  logic [7:0] cur_cyl_i
);

    localparam int XFER_MAX = SECTOR_BYTES * 512;
    localparam int CNT_MAX  = (XFER_MAX > ID_DELAY) ? XFER_MAX : ID_DELAY;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam int IDX_W    = $clog2(CMD_MAX_BYTES + 1);

    seq_state_t state_q, state_d;
    op_kind_t   op_q;
    logic       bad_q;
    logic       irq_q;
    logic [2:0] ridx_q;

    logic wr_ok, rd_res, rd_dat, first_wr, next_wr, last_param;
    op_kind_t op_new;
    logic [CMD_MAX_BYTES-1:0][7:0] cbytes;
    logic [IDX_W-1:0] cidx;

    logic [CNT_W-1:0] cnt_q, cnt_val, base_tot, xfer_total;
    logic             cnt_load, cnt_dec, irq_set;
    logic [8:0]       sectors;
    logic             eot_bad, two_heads, is_rw;
    logic [7:0]       res_byte;
    logic             res_last;

    assign op_new   = decode_op(fifo_wdata_i);
    assign wr_ok    = fifo_wr_i && (state_q == ST_CMD || state_q == ST_PARAM);
    assign rd_res   = fifo_rd_i && (state_q == ST_RESULT);
    assign rd_dat   = fifo_rd_i && (state_q == ST_XFER);
    assign first_wr = wr_ok && (state_q == ST_CMD);
    assign next_wr  = wr_ok && (state_q == ST_PARAM);
    assign last_param = next_wr && (cidx == IDX_W'(cmd_len(op_q) - 4'd1));

    fdc_cmd_capture #(.NBYTES(CMD_MAX_BYTES)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .first_i (first_wr),
        .next_i  (next_wr),
        .data_i  (fifo_wdata_i),
        .bytes_o (cbytes),
        .idx_o   (cidx)
    );

    fdc_down_counter #(.W(CNT_W)) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cnt_load),
        .val_i  (cnt_val),
        .dec_i  (cnt_dec),
        .cnt_o  (cnt_q)
    );

    fdc_result_mux u_result (
        .op_i    (op_q),
        .bytes_i (cbytes),
        .bad_i   (bad_q),
        .cyl_i   (cur_cyl_i),
        .idx_i   (ridx_q),
        .data_o  (res_byte),
        .last_o  (res_last)
    );

    // Execution sizing, evaluated when the last command byte lands
    assign is_rw      = (op_q == OP_RW_READ) || (op_q == OP_RW_VERIFY);
    assign eot_bad    = cbytes[6] > 8'(SPT);
    assign sectors    = (cbytes[6] >= cbytes[4]) ?
                        ({1'b0, cbytes[6]} - {1'b0, cbytes[4]} + 9'd1) : 9'd0;
    assign two_heads  = cbytes[0][7] && !cbytes[1][2];
    assign base_tot   = CNT_W'(sectors) * CNT_W'(SECTOR_BYTES);
    assign xfer_total = two_heads ? (base_tot << 1) : base_tot;

    // Next state
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cnt_dec  = 1'b0;
        irq_set  = 1'b0;
        unique case (state_q)
            ST_CMD: begin
                if (wr_ok) begin
                    state_d = (op_new == OP_INVALID) ? ST_RESULT : ST_PARAM;
                end
            end
            ST_PARAM: begin
                if (last_param) begin
                    unique case (op_q)
                        OP_READID: begin
                            state_d  = ST_DELAY;
                            cnt_load = 1'b1;
                            cnt_val  = CNT_W'(ID_DELAY);
                        end
                        OP_RW_READ: begin
                            if (eot_bad || dma_en_i || xfer_total == '0) begin
                                state_d = ST_RESULT;
                                irq_set = 1'b1;
                            end else begin
                                state_d  = ST_XFER;
                                cnt_load = 1'b1;
                                cnt_val  = xfer_total;
                            end
                        end
                        default: begin
                            state_d = ST_RESULT;
                            irq_set = 1'b1;
                        end
                    endcase
                end
            end
            ST_DELAY: begin
                if (cnt_q == '0) begin
                    state_d = ST_RESULT;
                    irq_set = 1'b1;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_XFER: begin
                if (rd_dat) begin
                    cnt_dec = 1'b1;
                    if (cnt_q == CNT_W'(1)) begin
                        state_d = ST_RESULT;
                        irq_set = 1'b1;
                    end
                end
            end
            ST_RESULT: begin
                if (rd_res && res_last) begin
                    state_d = ST_CMD;
                end
            end
            default: state_d = ST_CMD;
        endcase
    end

    // State register and phase bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CMD;
            op_q    <= OP_INVALID;
            bad_q   <= 1'b0;
            irq_q   <= 1'b0;
            ridx_q  <= '0;
        end else begin
            state_q <= state_d;
            if (first_wr) begin
                op_q  <= op_new;
                bad_q <= 1'b0;
            end else if (last_param) begin
                bad_q <= eot_bad && is_rw;
            end
            if (irq_set) begin
                irq_q <= 1'b1;
            end else if (rd_res && res_last) begin
                irq_q <= 1'b0;
            end
            if (state_q != ST_RESULT) begin
                ridx_q <= '0;
            end else if (rd_res) begin
                ridx_q <= ridx_q + 3'd1;
            end
        end
    end

    // Outputs
    always_comb begin
        status_o     = MSR_RQM;
        fifo_rdata_o = 8'h00;
        unique case (state_q)
            ST_CMD:    status_o = MSR_RQM;
            ST_PARAM:  status_o = MSR_RQM | MSR_BUSY;
            ST_DELAY:  status_o = MSR_BUSY;
            ST_XFER: begin
                status_o     = MSR_RQM | MSR_DIO | MSR_NONDMA | MSR_BUSY;
                fifo_rdata_o = media_data_i;
            end
            ST_RESULT: begin
                status_o     = MSR_RQM | MSR_DIO | MSR_BUSY;
                fifo_rdata_o = res_byte;
            end
            default:   status_o = MSR_RQM;
        endcase
    end

    assign irq_o       = irq_q;
    assign media_adv_o = rd_dat;

endmodule

// File: rtl/fdc_cmd_seq_chk.sv
module fdc_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_wr_i,
    input logic       fifo_rd_i,
    input logic [7:0] status_o,
    input logic       irq_o,
    input logic       media_adv_o,
    input logic       res_last
);

    p_status_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 8'h80 || status_o == 8'h90 || status_o == 8'h10 ||
         status_o == 8'hF0 || status_o == 8'hD0));

    p_no_irq_collect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 8'h90 || status_o == 8'h10) |-> !irq_o);

    p_irq_in_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> status_o == 8'hD0);

    p_last_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd_i && status_o == 8'hD0 && res_last) |=> (status_o == 8'h80 && !irq_o));

    p_wr_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr_i && !fifo_rd_i && status_o == 8'hD0) |=> (status_o == 8'hD0 && $stable(irq_o)));

    p_rd_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd_i && !fifo_wr_i && status_o == 8'h80) |=> status_o == 8'h80);

    p_media_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        media_adv_o |-> (fifo_rd_i && status_o == 8'hF0));

endmodule

bind fdc_cmd_seq fdc_cmd_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_wr_i   (fifo_wr_i),
    .fifo_rd_i   (fifo_rd_i),
    .status_o    (status_o),
    .irq_o       (irq_o),
    .media_adv_o (media_adv_o),
    .res_last    (res_last)
);

// File: tb/tb_fdc_cmd_seq.sv
module tb_fdc_cmd_seq;

    localparam int ID_DLY = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dma_en = 1'b0;
    logic       fifo_wr = 1'b0;
    logic [7:0] fifo_wdata = 8'h00;
    logic       fifo_rd = 1'b0;
    logic [7:0] fifo_rdata;
    logic [7:0] status;
    logic       irq;
    logic [7:0] media_data;
    logic       media_adv;
    logic [7:0] cur_cyl = 8'h00;

    int n_tests = 0;
    int n_fail  = 0;
    int media_cnt = 0;
    int exp_k = 0;
    logic [7:0] sb_q[$];

    always #4 clk = ~clk;

    fdc_cmd_seq #(.SPT(18), .SECTOR_BYTES(512), .ID_DELAY(ID_DLY)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .dma_en_i     (dma_en),
        .fifo_wr_i    (fifo_wr),
        .fifo_wdata_i (fifo_wdata),
        .fifo_rd_i    (fifo_rd),
        .fifo_rdata_o (fifo_rdata),
        .status_o     (status),
        .irq_o        (irq),
        .media_data_i (media_data),
        .media_adv_o  (media_adv),
        .cur_cyl_i    (cur_cyl)
    );

    function automatic logic [7:0] mbyte(input int k);
        return 8'(k) ^ 8'(k >> 8) ^ 8'h5A;
    endfunction

    assign media_data = mbyte(media_cnt);
    always @(posedge clk) if (media_adv) media_cnt <= media_cnt + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        fifo_wr = 1'b1; fifo_wdata = b;
        @(negedge clk);
        fifo_wr = 1'b0;
    endtask

    task automatic rd(output logic [7:0] b);
        @(negedge clk);
        fifo_rd = 1'b1;
        #1 b = fifo_rdata;
        @(negedge clk);
        fifo_rd = 1'b0;
    endtask

    task automatic rd_wr(input logic [7:0] wb, output logic [7:0] rb);
        @(negedge clk);
        fifo_rd = 1'b1; fifo_wr = 1'b1; fifo_wdata = wb;
        #1 rb = fifo_rdata;
        @(negedge clk);
        fifo_rd = 1'b0; fifo_wr = 1'b0;
    endtask

    // Driver side of the scoreboard: expected result bytes
    task automatic push7(input logic [7:0] a, b, c, d, e, f, g);
        sb_q.push_back(a); sb_q.push_back(b); sb_q.push_back(c); sb_q.push_back(d);
        sb_q.push_back(e); sb_q.push_back(f); sb_q.push_back(g);
    endtask

    // Monitor side: pop and compare each result byte as it is read
    task automatic drain(input string tag, input bit exp_irq);
        logic [7:0] b;
        int n;
        n = sb_q.size();
        for (int i = 0; i < n; i++) begin
            logic [7:0] e;
            e = sb_q.pop_front();
            if (i == n - 1) chk(irq == exp_irq, {tag, " R7 irq before last result"}, int'(irq), int'(exp_irq));
            rd(b);
            chk(b == e, tag, b, e);
        end
        chk(status == 8'h80 && !irq, {tag, " R7 back to command phase"}, {irq, status}, 8'h80);
    endtask

    task automatic cmd_rw(input logic [7:0] op, sel, cyl, hd, sec, n, eot);
        wr(op);
        chk(status == 8'h90, "R2 R3 param phase status", status, 8'h90);
        wr(sel);
        chk(!irq, "R8 irq low after drive select byte", irq, 0);
        wr(cyl); wr(hd); wr(sec); wr(n); wr(eot); wr(8'h1B); wr(8'hFF);
    endtask

    task automatic stream(input int nbytes, input string tag);
        logic [7:0] b;
        int bad = 0;
        for (int i = 0; i < nbytes; i++) begin
            if (i == nbytes - 1)
                chk(status == 8'hF0 && !irq, {tag, " R5 status before last data"}, {irq, status}, 8'hF0);
            rd(b);
            if (b != mbyte(exp_k)) bad++;
            exp_k++;
        end
        chk(bad == 0, {tag, " R5 data bytes mismatching"}, bad, 0);
        chk(media_cnt == exp_k, {tag, " R5 media advance count"}, media_cnt, exp_k);
        chk(status == 8'hD0 && irq, {tag, " R7 result phase with irq"}, {irq, status}, 9'h1D0);
    endtask

    initial begin
        #(8 * 190000);
        n_fail++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] b;
        int dcnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status == 8'h80, "R1 reset status", status, 8'h80);
        chk(!irq, "R1 reset irq", irq, 0);

        // R12: read in command phase is ignored
        rd(b);
        chk(status == 8'h80, "R12 read ignored in command phase", status, 8'h80);

        // R4: unknown opcode
        wr(8'h03);
        chk(status == 8'hD0 && !irq, "R4 invalid opcode result phase, no irq", {irq, status}, 8'hD0);
        sb_q.push_back(8'h80);
        drain("R4 invalid opcode", 1'b0);

        // R11: READ ID, head 1 drive 2, cylinder 8
        cur_cyl = 8'h08;
        wr(8'h0A);
        chk(status == 8'h90, "R2 R3 READ ID param phase", status, 8'h90);
        wr(8'h06);
        chk(!irq, "R8 irq low after READ ID select", irq, 0);
        dcnt = 0;
        while (status == 8'h10 && dcnt < 1000) begin
            if (irq) chk(0, "R8 irq during READ ID wait", irq, 0);
            dcnt++;
            @(negedge clk);
        end
        chk(dcnt == ID_DLY + 1, "R11 READ ID wait length", dcnt, ID_DLY + 1);
        chk(status == 8'hD0 && irq, "R11 R7 READ ID result with irq", {irq, status}, 9'h1D0);
        push7(8'h06, 8'h00, 8'h00, 8'h08, 8'h01, 8'h01, 8'h02);
        drain("R11 READ ID results", 1'b1);

        // R6 R9: DMA multi-track read from head 0
        dma_en = 1'b1;
        cmd_rw(8'hE6, 8'h00, 8'h03, 8'h00, 8'h01, 8'h02, 8'h02);
        chk(status == 8'hD0 && irq, "R6 DMA read goes to result", {irq, status}, 9'h1D0);
        chk(media_cnt == exp_k, "R6 DMA read moved no bytes", media_cnt, exp_k);
        // R12: lone write in result phase ignored
        wr(8'h0A);
        chk(status == 8'hD0 && irq, "R12 write ignored in result phase", {irq, status}, 9'h1D0);
        push7(8'h04, 8'h00, 8'h00, 8'h03, 8'h01, 8'h02, 8'h02);
        // R12: simultaneous read and write in result phase, read wins
        rd_wr(8'h0A, b);
        chk(b == sb_q.pop_front(), "R12 simultaneous strobes in result phase: read byte", b, 8'h04);
        chk(status == 8'hD0, "R12 simultaneous strobes in result phase: status", status, 8'hD0);
        drain("R9 DMA MT read results", 1'b1);

        // R6 R9: VERIFY, no multi-track, head 1 drive 1
        dma_en = 1'b0;
        cmd_rw(8'h16, 8'h05, 8'h07, 8'h01, 8'h02, 8'h02, 8'h09);
        chk(status == 8'hD0 && irq, "R6 VERIFY goes to result", {irq, status}, 9'h1D0);
        push7(8'h05, 8'h00, 8'h00, 8'h07, 8'h01, 8'h09, 8'h02);
        drain("R9 VERIFY results", 1'b1);

        // R5: non-DMA multi-track read, one sector per head
        cmd_rw(8'hE6, 8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h01);
        chk(status == 8'hF0, "R2 R5 non-DMA data phase status", status, 8'hF0);
        for (int i = 0; i < 10; i++) begin
            rd(b);
            chk(b == mbyte(exp_k), "R5 early data byte", b, mbyte(exp_k));
            exp_k++;
        end
        wr(8'h0A);
        chk(status == 8'hF0, "R12 write ignored in data phase", status, 8'hF0);
        stream(1024 - 10, "MT1");
        push7(8'h04, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h02);
        drain("R9 MT1 results", 1'b1);

        // R5: non-DMA multi-track read, 18 sectors per head
        cmd_rw(8'hE6, 8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h12);
        stream(2 * 512 * 18, "MT18");
        push7(8'h04, 8'h00, 8'h00, 8'h00, 8'h01, 8'h12, 8'h02);
        drain("R9 MT18 results", 1'b1);

        // R5 R9: single-track read on head 1, sectors 3..5
        cmd_rw(8'h66, 8'h04, 8'h02, 8'h01, 8'h03, 8'h02, 8'h05);
        stream(3 * 512, "ST3");
        push7(8'h04, 8'h00, 8'h00, 8'h02, 8'h01, 8'h05, 8'h02);
        drain("R9 head1 read results", 1'b1);

        // R10: end-of-track beyond sectors per track
        cmd_rw(8'hE6, 8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h13);
        chk(status == 8'hD0 && irq, "R10 no data phase for bad end sector", {irq, status}, 9'h1D0);
        chk(media_cnt == exp_k, "R10 no bytes moved", media_cnt, exp_k);
        push7(8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 8'h13, 8'h02);
        drain("R10 bad end sector results", 1'b1);

        // R12: simultaneous strobes in command phase, write wins
        cur_cyl = 8'h05;
        rd_wr(8'h4A, b);
        chk(status == 8'h90, "R12 simultaneous strobes in command phase", status, 8'h90);
        wr(8'h00);
        dcnt = 0;
        while (status == 8'h10 && dcnt < 1000) begin
            dcnt++;
            @(negedge clk);
        end
        chk(dcnt == ID_DLY + 1, "R11 second READ ID wait", dcnt, ID_DLY + 1);
        push7(8'h00, 8'h00, 8'h00, 8'h05, 8'h00, 8'h01, 8'h02);
        drain("R11 R3 READ ID via MFM opcode", 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule